// File: doc/BRIEF.md
# Wait/Hold Programmable Clock Divider

This block divides a clock domain's input clock by a ratio made of two separately programmed counts. A wait count sets the length of the output's high phase, and a hold count sets the length of its low phase. The output is high for wait+1 input cycles and low for hold+1 input cycles, so one output period lasts wait+hold+2 input cycles. The smallest ratio is 2, reached with both counts at zero.

Software writes one 32-bit configuration word. The wait count sits at bits [19:16] and the hold count at bits [23:20]. To request new counts, software writes them together with the update flag at bit 25. The flag reads 1 until the divider has taken the new counts. The divider takes them only when a full low phase ends, so no period is ever cut short, and it clears the flag in that same cycle.

Bit 31 selects bypass, in which the input clock drives the output directly. A width parameter narrows both count fields to 3 bits for one domain, which caps that domain's ratio at 16 instead of 32. Every other bit is stored and reads back exactly as written, and none of them changes the division.

Top module: `whdiv_top`

## Requirements
- R1: After reset the configuration word reads 0 and the output runs at ratio 2, high for 1 cycle and low for 1 cycle.
- R2: With active wait count W, every output high phase lasts W+1 input cycles, for every W from 0 to 2^FIELD_W-1.
- R3: With active hold count H, every output low phase lasts H+1 input cycles, for every H from 0 to 2^FIELD_W-1.
- R4: A write with bit 25 set reads back bit 25 as 1 while the current period completes with the old counts. The new counts take effect at the first end of a low phase, and bit 25 reads 0 from then on.
- R5: A write of new counts with bit 25 clear changes the readback but leaves the running high and low lengths unchanged.
- R6: Bits 0 to 15, bit 24 and bits 26 to 30 read back exactly as written and have no effect on the phase lengths.
- R7: With bit 31 set, the output equals the input clock (high while it is high, low while it is low). Clearing bit 31 brings back the divided output with the counts still active.
- R8: With FIELD_W=3 the counts are bits [18:16] and [22:20]; bits 19 and 23 read back as written but are ignored, and the largest ratio is 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock of the domain, also the register clock |
| rstN | input | 1 | Active-low reset |
| cfgWe | input | 1 | Write strobe for the configuration word |
| cfgWdata | input | 32 | Configuration word to write |
| cfgRdata | output | 32 | Current configuration word, including the pending update flag |
| clkOut | output | 1 | Divided clock, or the input clock when bypass is selected |

## Verification
The hardest case to create is an update request that arrives in the middle of a period. The old high and low phases must still run to their full length, the flag must stay set through them, and only then may the new lengths appear. The bench first programs long phases of 8 and 8 cycles. It locks onto a rising output and writes the new counts two cycles into that high phase. It then counts the rest of that high phase and the following low phase, checking the flag during the low phase and again at the first high cycle with the new counts. Exhaustive sweeps of every count pair on a 4-bit instance and a 3-bit instance cover the phase lengths. The 3-bit sweep sets the ignored top bit of each field.

// File: rtl/whdiv_pkg.sv
package whdiv_pkg;
  localparam int CFG_W    = 32;
  localparam int WAIT_LSB = 16;
  localparam int HOLD_LSB = 20;
  localparam int UPD_BIT  = 25;
  localparam int BYP_BIT  = 31;

  typedef struct packed {
    logic apply;
    logic bypass;
  } divStrb_t;
endpackage

// File: rtl/whdiv_ctrl.sv
module whdiv_ctrl
  import whdiv_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgWdata,
  input  logic               periodEnd,
  output logic [CFG_W-1:0]   cfgRdata,
  output divStrb_t           strb,
  output logic [FIELD_W-1:0] newWait,
  output logic [FIELD_W-1:0] newHold
);
  logic [CFG_W-1:0] cfgReg;

  // A new write wins over the self-clear, so a request written in the
  // boundary cycle stays pending for the next boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgWe) begin
      cfgReg <= cfgWdata;
    end else if (strb.apply) begin
      cfgReg[UPD_BIT] <= 1'b0;
    end
  end

  always_comb begin
    strb.apply  = periodEnd & cfgReg[UPD_BIT];
    strb.bypass = cfgReg[BYP_BIT];
    newWait     = cfgReg[WAIT_LSB +: FIELD_W];
    newHold     = cfgReg[HOLD_LSB +: FIELD_W];
    cfgRdata    = cfgReg;
  end
endmodule

// File: rtl/whdiv_dpath.sv
module whdiv_dpath
  import whdiv_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrb_t           strb,
  input  logic [FIELD_W-1:0] newWait,
  input  logic [FIELD_W-1:0] newHold,
  output logic               periodEnd,
  output logic               divOut,
  output logic               clkOut
);
  logic [FIELD_W-1:0] actWait;
  logic [FIELD_W-1:0] actHold;
  logic [FIELD_W-1:0] cnt;
  logic               phaseHigh;
  logic               highDone;

  always_comb begin
    highDone  = phaseHigh && (cnt == actWait);
    periodEnd = !phaseHigh && (cnt == actHold);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actWait   <= '0;
      actHold   <= '0;
      cnt       <= '0;
      phaseHigh <= 1'b1;
    end else if (highDone) begin
      phaseHigh <= 1'b0;
      cnt       <= '0;
    end else if (periodEnd) begin
      phaseHigh <= 1'b1;
      cnt       <= '0;
      if (strb.apply) begin
        actWait <= newWait;
        actHold <= newHold;
      end
    end else begin
      cnt <= cnt + FIELD_W'(1);
    end
  end

  assign divOut = phaseHigh;
  assign clkOut = strb.bypass ? clk : phaseHigh;
endmodule

// File: rtl/whdiv_top.sv
module whdiv_top
  import whdiv_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  output logic             clkOut
);
  divStrb_t           strb;
  logic               periodEnd;
  logic               divOut;
  logic [FIELD_W-1:0] newWait;
  logic [FIELD_W-1:0] newHold;

  whdiv_ctrl #(.FIELD_W(FIELD_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .periodEnd(periodEnd),
    .cfgRdata (cfgRdata),
    .strb     (strb),
    .newWait  (newWait),
    .newHold  (newHold)
  );

  whdiv_dpath #(.FIELD_W(FIELD_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .newWait  (newWait),
    .newHold  (newHold),
    .periodEnd(periodEnd),
    .divOut   (divOut),
    .clkOut   (clkOut)
  );
endmodule

// File: rtl/whdiv_chk.sv
module whdiv_chk #(
  parameter int FIELD_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic               updBit,
  input logic               periodEnd,
  input logic               divOut,
  input logic [FIELD_W-1:0] actWait,
  input logic [FIELD_W-1:0] actHold
);
  logic       prevOut;
  logic [7:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut <= 1'b1;
      runCnt  <= '0;
    end else begin
      prevOut <= divOut;
      runCnt  <= (divOut != prevOut) ? 8'd1 : runCnt + 8'd1;
    end
  end

  a_r2_high_len: assert property (@(posedge clk) disable iff (!rstN)
    (prevOut && !divOut) |-> (runCnt == 8'($past(actWait)) + 8'd1));

  a_r3_low_len: assert property (@(posedge clk) disable iff (!rstN)
    (!prevOut && divOut) |-> (runCnt == 8'($past(actHold)) + 8'd1));

  a_r4_pending_held: assert property (@(posedge clk) disable iff (!rstN)
    (updBit && !periodEnd && !cfgWe) |=> updBit);

  a_r4_cleared_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (updBit && periodEnd && !cfgWe) |=> !updBit);

  a_r5_counts_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(updBit && periodEnd) |=> ($stable(actWait) && $stable(actHold)));
endmodule

bind whdiv_top whdiv_chk #(.FIELD_W(FIELD_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .updBit   (cfgRdata[25]),
  .periodEnd(periodEnd),
  .divOut   (divOut),
  .actWait  (uDp.actWait),
  .actHold  (uDp.actHold)
);

// File: tb/sim_whdiv_top.sv
`timescale 1ns/1ps
module sim_whdiv_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        we0 = 1'b0, we1 = 1'b0;
  logic [31:0] wd0 = '0, wd1 = '0;
  logic [31:0] rd0, rd1;
  logic        out0, out1;
  int          checks = 0;
  int          failures = 0;

  localparam logic [31:0] UPD = 32'h0200_0000;
  localparam logic [31:0] BYP = 32'h8000_0000;

  always #5 clk = ~clk;

  whdiv_top #(.FIELD_W(4)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(we0), .cfgWdata(wd0),
    .cfgRdata(rd0), .clkOut(out0));

  whdiv_top #(.FIELD_W(3)) u1 (
    .clk(clk), .rstN(rstN), .cfgWe(we1), .cfgWdata(wd1),
    .cfgRdata(rd1), .clkOut(out1));

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic logic getOut(input int sel);
    return (sel == 0) ? out0 : out1;
  endfunction

  function automatic logic [31:0] getRd(input int sel);
    return (sel == 0) ? rd0 : rd1;
  endfunction

  task automatic writeCfg(input int sel, input logic [31:0] v);
    tick();
    if (sel == 0) begin we0 = 1'b1; wd0 = v; end
    else begin we1 = 1'b1; wd1 = v; end
    tick();
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  task automatic waitUpdClear(input int sel);
    int g = 0;
    while (getRd(sel)[25] && g < 200) begin tick(); g++; end
  endtask

  task automatic measure(input int sel, output int hi, output int lo);
    int g = 0;
    while (getOut(sel) != 1'b0 && g < 200) begin tick(); g++; end
    while (getOut(sel) == 1'b0 && g < 400) begin tick(); g++; end
    hi = 0;
    while (getOut(sel) == 1'b1 && hi < 100) begin hi++; tick(); end
    lo = 0;
    while (getOut(sel) == 1'b0 && lo < 100) begin lo++; tick(); end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int hi, lo, cnt;
    logic [31:0] v;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check(rd0 == 32'h0, "R1 readback u0", rd0, 32'h0);
    check(rd1 == 32'h0, "R1 readback u1", rd1, 32'h0);
    measure(0, hi, lo);
    check(hi == 1, "R1 reset high", hi, 1);
    check(lo == 1, "R1 reset low", lo, 1);

    // R2 R3 R6 full sweep on the 4-bit instance
    for (int w = 0; w < 16; w++) begin
      for (int h = 0; h < 16; h++) begin
        v = (32'(h) << 20) | (32'(w) << 16) | UPD | 32'h0000_3C5A
            ^ (32'(w * 16 + h) << 4);
        if (w[0]) v = v | 32'h5100_0000;
        writeCfg(0, v);
        waitUpdClear(0);
        check(rd0 == (v & ~UPD), "R6 R4 readback", rd0, v & ~UPD);
        measure(0, hi, lo);
        check(hi == w + 1, "R2 high length", hi, w + 1);
        check(lo == h + 1, "R3 low length", lo, h + 1);
      end
    end

    // R5 counts without the update flag have no effect
    v = (32'd1 << 20) | (32'd2 << 16);
    writeCfg(0, v);
    repeat (3) tick();
    check(rd0 == v, "R5 readback", rd0, v);
    measure(0, hi, lo);
    check(hi == 16, "R5 high unchanged", hi, 16);
    check(lo == 16, "R5 low unchanged", lo, 16);
    writeCfg(0, v | UPD);
    waitUpdClear(0);
    measure(0, hi, lo);
    check(hi == 3, "R5 high after update", hi, 3);
    check(lo == 2, "R5 low after update", lo, 2);

    // R4 request in the middle of a high phase
    writeCfg(0, (32'd7 << 20) | (32'd7 << 16) | UPD);
    waitUpdClear(0);
    measure(0, hi, lo);
    while (out0 != 1'b0) tick();
    while (out0 == 1'b0) tick();
    cnt = 1;
    tick();
    cnt++;
    we0 = 1'b1;
    wd0 = (32'd2 << 20) | (32'd1 << 16) | UPD;
    tick();
    cnt++;
    we0 = 1'b0;
    check(rd0[25] == 1'b1, "R4 flag pending in high", rd0[25], 1);
    while (out0 == 1'b1 && cnt < 100) begin tick(); cnt++; end
    cnt--;
    check(cnt == 8, "R4 old high completes", cnt, 8);
    lo = 0;
    while (out0 == 1'b0 && lo < 100) begin
      if (lo == 0) check(rd0[25] == 1'b1, "R4 flag pending in low", rd0[25], 1);
      lo++;
      tick();
    end
    check(lo == 8, "R4 old low completes", lo, 8);
    check(rd0[25] == 1'b0, "R4 flag cleared at boundary", rd0[25], 0);
    hi = 0;
    while (out0 == 1'b1 && hi < 100) begin hi++; tick(); end
    check(hi == 2, "R4 new high", hi, 2);
    lo = 0;
    while (out0 == 1'b0 && lo < 100) begin lo++; tick(); end
    check(lo == 3, "R4 new low", lo, 3);

    // R7 bypass
    v = BYP | (32'd2 << 20) | (32'd1 << 16);
    writeCfg(0, v);
    check(rd0 == v, "R7 readback", rd0, v);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      check(out0 == 1'b1, "R7 bypass high", out0, 1);
      @(negedge clk); #2;
      check(out0 == 1'b0, "R7 bypass low", out0, 0);
    end
    writeCfg(0, (32'd2 << 20) | (32'd1 << 16));
    measure(0, hi, lo);
    check(hi == 2, "R7 divided high restored", hi, 2);
    check(lo == 3, "R7 divided low restored", lo, 3);

    // R8 narrow instance, top field bits set but ignored
    for (int w = 0; w < 8; w++) begin
      for (int h = 0; h < 8; h++) begin
        v = (32'(h | 8) << 20) | (32'(w | 8) << 16) | UPD;
        writeCfg(1, v);
        waitUpdClear(1);
        check(rd1 == (v & ~UPD), "R8 readback", rd1, v & ~UPD);
        measure(1, hi, lo);
        check(hi == w + 1, "R8 high length", hi, w + 1);
        check(lo == h + 1, "R8 low length", lo, h + 1);
      end
    end

    summary();
    $finish;
  end
endmodule